// File: doc/BRIEF.md
# SIMD Immediate Lane ALU

This block is a single-cycle vector datapath. It combines every lane of a 128-bit source vector with a small immediate and produces a 128-bit destination value. A 2-bit format code is sampled with each operation and splits the vector into 16 byte lanes, 8 halfword lanes, 4 word lanes or 2 doubleword lanes. All lanes are computed in parallel, and each lane is fully isolated from its neighbours.

The operations are wrapping add and subtract, equality, signed and unsigned less-than, signed and unsigned less-or-equal, and signed and unsigned max and min. Each of these takes the low 5 bits of the immediate field. Whether those 5 bits are sign-extended or zero-extended depends on the operation. A further load-immediate operation ignores the source vector and copies a sign-extended 10-bit constant into every lane.

Operation codes outside the defined set raise an illegal flag instead of a write. The surrounding pipeline uses the registered write-enable to commit the destination. It uses the illegal flag to start its own exception handling.

Top module: `simd_imm_alu`

## Requirements
- R1: Inputs sampled on a rising edge with `in_valid_i` high appear on the outputs after that edge. A legal operation gives `wr_en_o`=1 and `illegal_o`=0. While reset is low, all outputs are zero.
- R2: Format code 0 selects 8-bit lanes, 1 selects 16-bit lanes, 2 selects 32-bit lanes and 3 selects 64-bit lanes. Lane 0 occupies the least significant bits.
- R3: Add (op 0) and subtract (op 1) combine each lane with `imm_i[4:0]` zero-extended. The result wraps modulo the lane width, and no carry or borrow crosses a lane boundary.
- R4: Equality (op 2), signed less-than (op 3), signed less-or-equal (op 5), signed max (op 7) and signed min (op 9) sign-extend `imm_i[4:0]` to the lane width and treat lanes as two's complement.
- R5: Unsigned less-than (op 4), unsigned less-or-equal (op 6), unsigned max (op 8) and unsigned min (op 10) zero-extend `imm_i[4:0]` and compare both operands as unsigned.
- R6: A compare writes a lane of all ones when its condition holds and a lane of all zeros when it does not.
- R7: Max and min write the chosen operand's lane bits unchanged.
- R8: Load-immediate (op 11) sign-extends the 10-bit `imm_i` to the lane width and writes it to every lane, ignoring `src_i`. For 8-bit lanes only `imm_i[7:0]` is written.
- R9: Op codes 12 to 15 give `illegal_o`=1, `wr_en_o`=0 and a destination of zero.
- R10: A cycle with `in_valid_i` low gives `wr_en_o`=0 and `illegal_o`=0, and the destination keeps its previous value, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operation present this cycle |
| fmt_i | input | 2 | Lane format code |
| op_i | input | 4 | Operation select |
| src_i | input | 128 | Source vector |
| imm_i | input | 10 | Raw immediate field |
| dest_o | output | 128 | Registered destination vector |
| wr_en_o | output | 1 | Destination write enable |
| illegal_o | output | 1 | Reserved operation flag |

## Verification
The assertions assume that `in_valid_i`, `fmt_i`, `op_i` and `imm_i` are stable and known at each rising edge after reset. They also assume that the destination only needs to hold while `in_valid_i` is low. The stimulus changes every input on the falling edge and always drives defined values, including during idle cycles, which deliberately carry illegal op codes and new source data. The lane values are chosen at wrap points, at the extremes of the signed and unsigned ranges, and equal to the extended immediate, so that each extension rule and each compare boundary is tested.

// File: rtl/simd_imm_pkg.sv
package simd_imm_pkg;

    typedef enum logic [3:0] {
        OP_ADD   = 4'd0,
        OP_SUB   = 4'd1,
        OP_EQ    = 4'd2,
        OP_LT_S  = 4'd3,
        OP_LT_U  = 4'd4,
        OP_LE_S  = 4'd5,
        OP_LE_U  = 4'd6,
        OP_MAX_S = 4'd7,
        OP_MAX_U = 4'd8,
        OP_MIN_S = 4'd9,
        OP_MIN_U = 4'd10,
        OP_SPLAT = 4'd11
    } op_e;

    localparam int NUM_OPS = 12;

endpackage

// File: rtl/simd_lane_op.sv
module simd_lane_op
    import simd_imm_pkg::*;
#(
    parameter int LW     = 8,
    parameter int SIMM_W = 5,
    parameter int LIMM_W = 10
) (
    input  logic [LW-1:0]     a_i,
    input  op_e               op_i,
    input  logic [LIMM_W-1:0] imm_i,
    output logic [LW-1:0]     y_o
);

    logic [LW-1:0] zx_imm;
    logic [LW-1:0] sx_imm;
    logic [LW-1:0] splat_val;
    logic          lt_s, le_s, lt_u, le_u, eq;

    assign zx_imm = {{(LW-SIMM_W){1'b0}}, imm_i[SIMM_W-1:0]};
    assign sx_imm = {{(LW-SIMM_W){imm_i[SIMM_W-1]}}, imm_i[SIMM_W-1:0]};

    generate
        if (LW > LIMM_W) begin : g_sext
            assign splat_val = {{(LW-LIMM_W){imm_i[LIMM_W-1]}}, imm_i};
        end else begin : g_trunc
            assign splat_val = imm_i[LW-1:0];
        end
    endgenerate

    assign eq   = (a_i == sx_imm);
    assign lt_s = ($signed(a_i) <  $signed(sx_imm));
    assign le_s = ($signed(a_i) <= $signed(sx_imm));
    assign lt_u = (a_i <  zx_imm);
    assign le_u = (a_i <= zx_imm);

    always_comb begin
        case (op_i)
            OP_ADD:   y_o = a_i + zx_imm;
            OP_SUB:   y_o = a_i - zx_imm;
            OP_EQ:    y_o = {LW{eq}};
            OP_LT_S:  y_o = {LW{lt_s}};
            OP_LT_U:  y_o = {LW{lt_u}};
            OP_LE_S:  y_o = {LW{le_s}};
            OP_LE_U:  y_o = {LW{le_u}};
            OP_MAX_S: y_o = lt_s ? sx_imm : a_i;
            OP_MAX_U: y_o = lt_u ? zx_imm : a_i;
            OP_MIN_S: y_o = lt_s ? a_i : sx_imm;
            OP_MIN_U: y_o = lt_u ? a_i : zx_imm;
            OP_SPLAT: y_o = splat_val;
            default:  y_o = '0;
        endcase
    end

endmodule

// File: rtl/simd_lane_bank.sv
module simd_lane_bank
    import simd_imm_pkg::*;
#(
    parameter int VEC_W  = 128,
    parameter int LW     = 8,
    parameter int SIMM_W = 5,
    parameter int LIMM_W = 10
) (
    input  logic [VEC_W-1:0]  a_i,
    input  op_e               op_i,
    input  logic [LIMM_W-1:0] imm_i,
    output logic [VEC_W-1:0]  y_o
);

    localparam int LANES = VEC_W / LW;

    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            simd_lane_op #(
                .LW     (LW),
                .SIMM_W (SIMM_W),
                .LIMM_W (LIMM_W)
            ) i_lane (
                .a_i   (a_i[l*LW +: LW]),
                .op_i  (op_i),
                .imm_i (imm_i),
                .y_o   (y_o[l*LW +: LW])
            );
        end
    endgenerate

endmodule

// File: rtl/simd_imm_alu.sv
module simd_imm_alu
    import simd_imm_pkg::*;
#(
    parameter int VEC_W      = 128,
    parameter int LANE_MIN_W = 8,
    parameter int FMT_W      = 2,
    parameter int OP_W       = 4,
    parameter int SIMM_W     = 5,
    parameter int LIMM_W     = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid_i,
    input  logic [FMT_W-1:0]  fmt_i,
    input  logic [OP_W-1:0]   op_i,
    input  logic [VEC_W-1:0]  src_i,
    input  logic [LIMM_W-1:0] imm_i,
    output logic [VEC_W-1:0]  dest_o,
    output logic              wr_en_o,
    output logic              illegal_o
);

    localparam int              NUM_FMT  = 1 << FMT_W;
    localparam logic [OP_W-1:0] OP_LIMIT = OP_W'(NUM_OPS);

    typedef struct packed {
        logic [VEC_W-1:0] dest;
        logic             wr_en;
        logic             illegal;
    } state_t;

    state_t           st_d, st_q;
    logic [VEC_W-1:0] bank_y [NUM_FMT];
    logic             op_legal;
    op_e              op_sel;

    assign op_legal = (op_i < OP_LIMIT);
    assign op_sel   = op_e'(op_i);

    generate
        for (genvar f = 0; f < NUM_FMT; f++) begin : g_fmt
            simd_lane_bank #(
                .VEC_W  (VEC_W),
                .LW     (LANE_MIN_W << f),
                .SIMM_W (SIMM_W),
                .LIMM_W (LIMM_W)
            ) i_bank (
                .a_i   (src_i),
                .op_i  (op_sel),
                .imm_i (imm_i),
                .y_o   (bank_y[f])
            );
        end
    endgenerate

    always_comb begin
        st_d         = st_q;
        st_d.wr_en   = 1'b0;
        st_d.illegal = 1'b0;
        if (in_valid_i) begin
            if (op_legal) begin
                st_d.wr_en = 1'b1;
                st_d.dest  = bank_y[fmt_i];
            end else begin
                st_d.illegal = 1'b1;
                st_d.dest    = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dest_o    = st_q.dest;
    assign wr_en_o   = st_q.wr_en;
    assign illegal_o = st_q.illegal;

    // R1: a legal request produces a write on the next cycle
    a_r1_legal_write: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && op_i < OP_LIMIT) |=> (wr_en_o && !illegal_o));

    // R9: a reserved code flags and zeroes the destination
    a_r9_illegal_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && op_i >= OP_LIMIT) |=> (illegal_o && !wr_en_o && dest_o == '0));

    // R10: idle cycles keep the destination and raise nothing
    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid_i |=> (!wr_en_o && !illegal_o && $stable(dest_o)));

    // R6: a narrowest-lane compare yields a full mask in lane 0
    a_r6_mask_lane0: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && fmt_i == '0 && op_i >= OP_W'(OP_EQ) && op_i <= OP_W'(OP_LE_U))
        |=> (dest_o[LANE_MIN_W-1:0] == '0 || dest_o[LANE_MIN_W-1:0] == '1));

    // R8: a narrowest-lane splat copies the low immediate bits into neighbouring lanes
    a_r8_splat_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && fmt_i == '0 && op_i == OP_W'(OP_SPLAT))
        |=> (dest_o[LANE_MIN_W-1:0] == $past(imm_i[LANE_MIN_W-1:0])
             && dest_o[2*LANE_MIN_W-1:LANE_MIN_W] == dest_o[LANE_MIN_W-1:0]));

endmodule

// File: tb/test_simd_imm_alu.sv
module test_simd_imm_alu;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid_i = 1'b0;
    logic [1:0]   fmt_i = '0;
    logic [3:0]   op_i = '0;
    logic [127:0] src_i = '0;
    logic [9:0]   imm_i = '0;
    logic [127:0] dest_o;
    logic         wr_en_o;
    logic         illegal_o;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    simd_imm_alu i_simd_imm_alu (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid_i (in_valid_i),
        .fmt_i      (fmt_i),
        .op_i       (op_i),
        .src_i      (src_i),
        .imm_i      (imm_i),
        .dest_o     (dest_o),
        .wr_en_o    (wr_en_o),
        .illegal_o  (illegal_o)
    );

    typedef struct packed {
        logic [1:0]   fmt;
        logic [3:0]   op;
        logic [9:0]   imm;
        logic [127:0] src;
        logic [127:0] exp;
        logic         ill;
        logic [3:0]   req;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        // R3 byte add, wrap inside each lane
        '{2'd0, 4'd0, 10'h01F, 128'hFFFEFDFC_80817F7E_0F0E0D0C_03020100,
          128'h1E1D1C1B_9FA09E9D_2E2D2C2B_2221201F, 1'b0, 4'd3},
        // R3 halfword subtract, borrow kept in lane
        '{2'd1, 4'd1, 10'h005, 128'h00000001_00050006_8000FFFF_12340004,
          128'hFFFBFFFC_00000001_7FFBFFFA_122FFFFF, 1'b0, 4'd3},
        // R4 byte equality with sign-extended -1
        '{2'd0, 4'd2, 10'h01F, 128'hFF1F00FF_00000000_00000000_000000FF,
          128'hFF0000FF_00000000_00000000_000000FF, 1'b0, 4'd4},
        // R4 word signed less-than -16
        '{2'd2, 4'd3, 10'h010, 128'h80000000_FFFFFFF0_FFFFFFEF_00000000,
          128'hFFFFFFFF_00000000_FFFFFFFF_00000000, 1'b0, 4'd4},
        // R5 word unsigned less-than 16
        '{2'd2, 4'd4, 10'h010, 128'h80000000_0000000F_00000010_00000000,
          128'h00000000_FFFFFFFF_00000000_FFFFFFFF, 1'b0, 4'd5},
        // R6 halfword signed less-or-equal -2
        '{2'd1, 4'd5, 10'h01E, 128'hFFFEFFFF_80007FFF_0000FFFD_0001FFF0,
          128'hFFFF0000_FFFF0000_0000FFFF_0000FFFF, 1'b0, 4'd6},
        // R6 byte unsigned less-or-equal 30
        '{2'd0, 4'd6, 10'h01E, 128'h1E1F00FF_1D800000_00000000_00000000,
          128'hFF00FF00_FF00FFFF_FFFFFFFF_FFFFFFFF, 1'b0, 4'd6},
        // R7 doubleword signed max -16
        '{2'd3, 4'd7, 10'h010, 128'h80000000_00000000_00000000_00000005,
          128'hFFFFFFFF_FFFFFFF0_00000000_00000005, 1'b0, 4'd7},
        // R7 doubleword unsigned max 16
        '{2'd3, 4'd8, 10'h010, 128'h80000000_00000000_00000000_00000005,
          128'h80000000_00000000_00000000_00000010, 1'b0, 4'd7},
        // R7 byte signed min -5
        '{2'd0, 4'd9, 10'h01B, 128'h8000FB7F_FA050505_05050505_05050505,
          128'h80FBFBFB_FAFBFBFB_FBFBFBFB_FBFBFBFB, 1'b0, 4'd7},
        // R7 halfword unsigned min 27
        '{2'd1, 4'd10, 10'h01B, 128'h80000000_001A001C_FFFF1234_0001001B,
          128'h001B0000_001A001B_001B001B_0001001B, 1'b0, 4'd7},
        // R8 byte splat keeps low 8 bits only
        '{2'd0, 4'd11, 10'h2A5, 128'hDEADBEEF_01234567_89ABCDEF_55AA55AA,
          {16{8'hA5}}, 1'b0, 4'd8},
        // R8 halfword splat sign-extends
        '{2'd1, 4'd11, 10'h2A5, 128'hFFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF,
          {8{16'hFEA5}}, 1'b0, 4'd8},
        // R8 doubleword splat positive
        '{2'd3, 4'd11, 10'h0FF, 128'h12345678_9ABCDEF0_0FEDCBA9_87654321,
          {2{64'h00000000_000000FF}}, 1'b0, 4'd8},
        // R8 word splat most negative
        '{2'd2, 4'd11, 10'h200, 128'h0,
          {4{32'hFFFFFE00}}, 1'b0, 4'd8},
        // R9 reserved code 12
        '{2'd2, 4'd12, 10'h001, 128'hFFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF,
          128'h0, 1'b1, 4'd9},
        // R9 reserved code 15
        '{2'd0, 4'd15, 10'h3FF, 128'h01010101_01010101_01010101_01010101,
          128'h0, 1'b1, 4'd9},
        // R3 word add: immediate is zero-extended, not -1
        '{2'd2, 4'd0, 10'h01F, 128'hFFFFFFFF_7FFFFFFF_00000000_FFFFFFE1,
          128'h0000001E_8000001E_0000001F_00000000, 1'b0, 4'd3},
        // R2 doubleword subtract borrows across the word boundary within the lane
        '{2'd3, 4'd1, 10'h001, 128'h00000000_00000000_00000001_00000000,
          128'hFFFFFFFF_FFFFFFFF_00000000_FFFFFFFF, 1'b0, 4'd2}
    };

    task automatic check_val(input string req, input string what,
                             input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    task automatic issue(input logic v, input logic [1:0] f, input logic [3:0] o,
                         input logic [127:0] s, input logic [9:0] im);
        @(negedge clk);
        in_valid_i = v;
        fmt_i      = f;
        op_i       = o;
        src_i      = s;
        imm_i      = im;
        @(posedge clk);
        #1;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cycles);
            finish_run();
        end
    end

    initial begin
        logic [127:0] held;
        string tag;
        // R1 reset state
        repeat (3) @(posedge clk);
        #1;
        check_val("R1", "reset dest", dest_o, '0);
        check_val("R1", "reset wr_en", {127'b0, wr_en_o}, '0);
        check_val("R1", "reset illegal", {127'b0, illegal_o}, '0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            issue(1'b1, VECS[i].fmt, VECS[i].op, VECS[i].src, VECS[i].imm);
            tag = $sformatf("R%0d", VECS[i].req);
            check_val(tag, $sformatf("vec %0d dest", i), dest_o, VECS[i].exp);
            check_val("R1", $sformatf("vec %0d wr_en", i), {127'b0, wr_en_o},
                      {127'b0, ~VECS[i].ill});
            check_val("R9", $sformatf("vec %0d illegal", i), {127'b0, illegal_o},
                      {127'b0, VECS[i].ill});
        end

        // R10: idle cycle with new data and a reserved code changes nothing
        issue(1'b1, 2'd0, 4'd0, 128'h0, 10'h001);
        held = dest_o;
        check_val("R3", "byte add one", held, {16{8'h01}});
        issue(1'b0, 2'd3, 4'd14, 128'hFFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF, 10'h3FF);
        check_val("R10", "idle dest hold", dest_o, held);
        check_val("R10", "idle wr_en", {127'b0, wr_en_o}, '0);
        check_val("R10", "idle illegal", {127'b0, illegal_o}, '0);
        issue(1'b0, 2'd0, 4'd11, 128'h0, 10'h155);
        check_val("R10", "idle splat ignored", dest_o, held);

        // R9 after a legal write the reserved code clears the destination
        issue(1'b1, 2'd1, 4'd13, 128'h5, 10'h0);
        check_val("R9", "reserved clears dest", dest_o, '0);
        check_val("R9", "reserved flag", {127'b0, illegal_o}, 128'd1);

        // R1 back-to-back writes, then reset mid-run
        issue(1'b1, 2'd2, 4'd0, 128'h0, 10'h003);
        check_val("R1", "word add after illegal", dest_o, {4{32'h00000003}});
        check_val("R1", "wr_en after illegal", {127'b0, wr_en_o}, 128'd1);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check_val("R1", "mid-run reset dest", dest_o, '0);
        check_val("R1", "mid-run reset wr_en", {127'b0, wr_en_o}, '0);

        finish_run();
    end

endmodule